// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Periodic Interrupt

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours in 24-hour form, day of month, month, two-digit year, and a separate 3-bit weekday. A one-second step is derived by counting pulses of a 32 kHz enable input. Month lengths follow the calendar, with February gaining a day in every year divisible by four.

Software reaches every field through a small byte-wide register port: a write strobe, a read strobe, a 4-bit address and registered read data. On top of plain timekeeping the block can snap the time to the nearest whole minute at the next second. It can lengthen or shorten the last second of every hour by a signed number of 32 kHz pulses to cancel oscillator error. It raises an alarm interrupt when the time equals a programmed date and time, and a periodic interrupt once per second, minute, hour or day. Interrupt flags are visible through a status register that returns its value from the previous status read, so a dummy read must come first.

Top module: `rtc_bcd_top`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, day and month read 0x01, weekday, control, drift, status and both interrupt outputs read 0, and `rdata` carries the addressed register one cycle after `rd_en`.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday, 7 to 12 the alarm seconds to year in the same order, 13 control, 14 drift, 15 status; unused high bits read 0: bit 7 of seconds and minutes, bits 7:6 of hours and day, bits 7:5 of month, bits 7:3 of weekday.
- R3: The time advances by one second on the TICKS_PER_SEC-th `tick32` pulse after the previous step, and a write to the seconds register restarts that pulse count from zero.
- R4: Seconds and minutes count in BCD from 00 to 59 and hours from 00 to 23, each carrying into the next field on rollover.
- R5: The day rolls to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months except 02, and in month 02 after 29 when the year is divisible by four (00, 12, 24...) and after 28 otherwise; the month then advances.
- R6: Month 12 rolls to 01 with the year advancing, year 99 rolls to 00, and the weekday advances with every day change, wrapping from 6 to 0.
- R7: Writing control bit 0 as 1 sets a round request (read back on bit 0); at the next second step the seconds become 00, the minute advances (with carries) if the seconds were 30 or more, and the request clears.
- R8: The drift register holds a signed 8-bit value C; the second that starts at xx:59:59 lasts TICKS_PER_SEC minus C pulses, and every other second is unaffected.
- R9: With control bit 1 (alarm enable) set, a step whose new time equals the alarm registers in seconds through year sets status bit 0 and drives `irq_alarm` high; writing status with bit 0 set clears it.
- R10: With control bit 1 clear, a matching time sets no alarm flag and leaves `irq_alarm` low.
- R11: With control bit 4 set, a step sets status bit 1 and `irq_period` according to control bits 3:2: 00 every step, 01 when the new seconds are 00, 10 also with minutes 00, 11 also with hours 00; writing status with bit 1 set clears it.
- R12: A status read returns the flags captured at the previous status read and then captures the current flags, so after an event the first read shows the old value and the second the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick32 | input | 1 | One-cycle enable per 32 kHz oscillator period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq_alarm | output | 1 | Alarm interrupt, high while the alarm flag is set |
| irq_period | output | 1 | Periodic interrupt, high while the periodic flag is set |

## Verification
The bench aims at the places where a calendar quietly goes wrong: the BCD units-to-tens carry at 09, the 23:59:59 cascade through day, month and year, February in leap and common years including year 00 and a year with odd tens digit, and the 30-day months; a design with a binary carry or a wrong leap test would show 0x0A, 0x30 February days or a wrong month. Rounding is tried just below and just above the half minute and across an hour, where a wrong threshold or a lost carry leaves the wrong minute. The drift value is applied with both signs and also at a non-hour second, which catches a compensation applied every second or with inverted sign. The stale-then-fresh status read and the alarm-disabled case show whether flags are latched and gated as required.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_key_t;

  typedef struct packed {
    rtc_key_t   key;
    logic [2:0] wday;
  } rtc_time_t;

  typedef enum logic [1:0] {
    PER_SEC  = 2'b00,
    PER_MIN  = 2'b01,
    PER_HOUR = 2'b10,
    PER_DAY  = 2'b11
  } per_sel_e;

  localparam logic [3:0] ADR_SEC   = 4'h0;
  localparam logic [3:0] ADR_MIN   = 4'h1;
  localparam logic [3:0] ADR_HOUR  = 4'h2;
  localparam logic [3:0] ADR_DAY   = 4'h3;
  localparam logic [3:0] ADR_MON   = 4'h4;
  localparam logic [3:0] ADR_YEAR  = 4'h5;
  localparam logic [3:0] ADR_WDAY  = 4'h6;
  localparam logic [3:0] ADR_ASEC  = 4'h7;
  localparam logic [3:0] ADR_AMIN  = 4'h8;
  localparam logic [3:0] ADR_AHOUR = 4'h9;
  localparam logic [3:0] ADR_ADAY  = 4'hA;
  localparam logic [3:0] ADR_AMON  = 4'hB;
  localparam logic [3:0] ADR_AYEAR = 4'hC;
  localparam logic [3:0] ADR_CTRL  = 4'hD;
  localparam logic [3:0] ADR_DRIFT = 4'hE;
  localparam logic [3:0] ADR_STAT  = 4'hF;

  // Field masks shared by time and alarm registers
  localparam logic [7:0] MSK_SEC  = 8'h7F;
  localparam logic [7:0] MSK_MIN  = 8'h7F;
  localparam logic [7:0] MSK_HOUR = 8'h3F;
  localparam logic [7:0] MSK_DAY  = 8'h3F;
  localparam logic [7:0] MSK_MON  = 8'h1F;

  // Packed BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic leap_year(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Time after one second step, or after a round-to-minute step
  function automatic rtc_time_t rtc_advance(input rtc_time_t t, input logic round);
    rtc_time_t n;
    logic      c;
    n = t;
    if (round) begin
      n.key.sec = 8'h00;
      c = (t.key.sec >= 8'h30);
    end else if (t.key.sec >= 8'h59) begin
      n.key.sec = 8'h00;
      c = 1'b1;
    end else begin
      n.key.sec = bcd_inc(t.key.sec);
      c = 1'b0;
    end
    if (c) begin
      if (t.key.min >= 8'h59) n.key.min = 8'h00;
      else begin n.key.min = bcd_inc(t.key.min); c = 1'b0; end
    end
    if (c) begin
      if (t.key.hour >= 8'h23) n.key.hour = 8'h00;
      else begin n.key.hour = bcd_inc(t.key.hour); c = 1'b0; end
    end
    if (c) begin
      n.wday = (t.wday >= 3'd6) ? 3'd0 : t.wday + 3'd1;
      if (t.key.day >= month_last_day(t.key.mon, t.key.year)) n.key.day = 8'h01;
      else begin n.key.day = bcd_inc(t.key.day); c = 1'b0; end
    end
    if (c) begin
      if (t.key.mon >= 8'h12) n.key.mon = 8'h01;
      else begin n.key.mon = bcd_inc(t.key.mon); c = 1'b0; end
    end
    if (c) begin
      if (t.key.year >= 8'h99) n.key.year = 8'h00;
      else n.key.year = bcd_inc(t.key.year);
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int COMP_W        = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     restart,
  input  logic                     hour_last,
  input  logic signed [COMP_W-1:0] comp,
  output logic                     sec_step
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC + (2 ** (COMP_W - 1)) + 1);
  localparam int LIM_W = CNT_W + 1;
  localparam logic signed [LIM_W-1:0] PER_S = LIM_W'(TICKS_PER_SEC);
  localparam logic signed [LIM_W-1:0] ONE_S = 1;

  logic        [CNT_W-1:0] cnt_q;
  logic signed [LIM_W-1:0] lim_raw;
  logic signed [LIM_W-1:0] lim;

  always_comb begin
    lim_raw = hour_last ? (PER_S - LIM_W'(comp)) : PER_S;
    lim     = (lim_raw < ONE_S) ? ONE_S : lim_raw;
  end

  assign sec_step = tick_en && ($signed({1'b0, cnt_q}) >= (lim - ONE_S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (tick_en)  cnt_q <= sec_step ? '0 : cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       round_pend,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output rtc_time_t  cur_t,
  output rtc_time_t  next_t
);

  assign next_t = rtc_advance(cur_t, round_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_t <= '{key: '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                        day: 8'h01, mon: 8'h01, year: 8'h00},
                 wday: 3'd0};
    end else begin
      if (step) cur_t <= next_t;
      if (wr_en) begin
        case (addr)
          ADR_SEC:  cur_t.key.sec  <= wdata & MSK_SEC;
          ADR_MIN:  cur_t.key.min  <= wdata & MSK_MIN;
          ADR_HOUR: cur_t.key.hour <= wdata & MSK_HOUR;
          ADR_DAY:  cur_t.key.day  <= wdata & MSK_DAY;
          ADR_MON:  cur_t.key.mon  <= wdata & MSK_MON;
          ADR_YEAR: cur_t.key.year <= wdata;
          ADR_WDAY: cur_t.wday     <= wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  // R6
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && cur_t.wday <= 3'd6) |=> (cur_t.wday <= 3'd6));

  // R7
  round_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && round_pend && !wr_en) |=> (cur_t.key.sec == 8'h00));

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  rtc_key_t   next_key,
  input  logic       alarm_en,
  input  logic       per_en,
  input  per_sel_e   per_sel,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output rtc_key_t   alarm_key,
  output logic       alarm_flag,
  output logic       period_flag
);

  logic alarm_hit;
  logic period_hit;
  logic clr_alarm;
  logic clr_period;

  assign alarm_hit = step && alarm_en && (next_key == alarm_key);

  always_comb begin
    case (per_sel)
      PER_SEC:  period_hit = 1'b1;
      PER_MIN:  period_hit = (next_key.sec == 8'h00);
      PER_HOUR: period_hit = (next_key.sec == 8'h00) && (next_key.min == 8'h00);
      default:  period_hit = (next_key.sec == 8'h00) && (next_key.min == 8'h00) &&
                             (next_key.hour == 8'h00);
    endcase
    period_hit = period_hit && step && per_en;
  end

  assign clr_alarm  = wr_en && (addr == ADR_STAT) && wdata[0];
  assign clr_period = wr_en && (addr == ADR_STAT) && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_key <= '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                     day: 8'h01, mon: 8'h01, year: 8'h00};
    end else if (wr_en) begin
      case (addr)
        ADR_ASEC:  alarm_key.sec  <= wdata & MSK_SEC;
        ADR_AMIN:  alarm_key.min  <= wdata & MSK_MIN;
        ADR_AHOUR: alarm_key.hour <= wdata & MSK_HOUR;
        ADR_ADAY:  alarm_key.day  <= wdata & MSK_DAY;
        ADR_AMON:  alarm_key.mon  <= wdata & MSK_MON;
        ADR_AYEAR: alarm_key.year <= wdata;
        default: ;
      endcase
    end
  end

  // Event set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag  <= 1'b0;
      period_flag <= 1'b0;
    end else begin
      if (alarm_hit)       alarm_flag <= 1'b1;
      else if (clr_alarm)  alarm_flag <= 1'b0;
      if (period_hit)      period_flag <= 1'b1;
      else if (clr_period) period_flag <= 1'b0;
    end
  end

  // R9
  alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(step && alarm_en));

  // R11
  period_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_flag) |-> $past(step && per_en));

endmodule

// File: rtl/rtc_bcd_top.sv
module rtc_bcd_top
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int COMP_W        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick32,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_alarm,
  output logic       irq_period
);

  rtc_time_t               cur_t;
  rtc_time_t               next_t;
  rtc_key_t                alarm_key;
  logic                    sec_step;
  logic                    hour_last;
  logic                    sec_restart;
  logic                    round_pend;
  logic                    alarm_en;
  logic                    per_en;
  per_sel_e                per_sel;
  logic signed [COMP_W-1:0] drift_q;
  logic                    alarm_flag;
  logic                    period_flag;
  logic [1:0]              stat_snap;
  logic [7:0]              rd_mux;
  logic                    ctrl_wr;

  assign hour_last   = (cur_t.key.sec == 8'h59) && (cur_t.key.min == 8'h59);
  assign sec_restart = wr_en && (addr == ADR_SEC);
  assign ctrl_wr     = wr_en && (addr == ADR_CTRL);

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .COMP_W       (COMP_W)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick32),
    .restart  (sec_restart),
    .hour_last(hour_last),
    .comp     (drift_q),
    .sec_step (sec_step)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (sec_step),
    .round_pend(round_pend),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .cur_t     (cur_t),
    .next_t    (next_t)
  );

  rtc_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (sec_step),
    .next_key   (next_t.key),
    .alarm_en   (alarm_en),
    .per_en     (per_en),
    .per_sel    (per_sel),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .alarm_key  (alarm_key),
    .alarm_flag (alarm_flag),
    .period_flag(period_flag)
  );

  // Control and drift registers; round request clears on the step that uses it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_pend <= 1'b0;
      alarm_en   <= 1'b0;
      per_en     <= 1'b0;
      per_sel    <= PER_SEC;
      drift_q    <= '0;
    end else begin
      if (ctrl_wr && wdata[0]) round_pend <= 1'b1;
      else if (sec_step)       round_pend <= 1'b0;
      if (ctrl_wr) begin
        alarm_en <= wdata[1];
        per_sel  <= per_sel_e'(wdata[3:2]);
        per_en   <= wdata[4];
      end
      if (wr_en && addr == ADR_DRIFT) drift_q <= COMP_W'(wdata);
    end
  end

  always_comb begin
    case (addr)
      ADR_SEC:   rd_mux = cur_t.key.sec;
      ADR_MIN:   rd_mux = cur_t.key.min;
      ADR_HOUR:  rd_mux = cur_t.key.hour;
      ADR_DAY:   rd_mux = cur_t.key.day;
      ADR_MON:   rd_mux = cur_t.key.mon;
      ADR_YEAR:  rd_mux = cur_t.key.year;
      ADR_WDAY:  rd_mux = {5'd0, cur_t.wday};
      ADR_ASEC:  rd_mux = alarm_key.sec;
      ADR_AMIN:  rd_mux = alarm_key.min;
      ADR_AHOUR: rd_mux = alarm_key.hour;
      ADR_ADAY:  rd_mux = alarm_key.day;
      ADR_AMON:  rd_mux = alarm_key.mon;
      ADR_AYEAR: rd_mux = alarm_key.year;
      ADR_CTRL:  rd_mux = {3'd0, per_en, per_sel, alarm_en, round_pend};
      ADR_DRIFT: rd_mux = 8'(drift_q);
      default:   rd_mux = {6'd0, stat_snap};
    endcase
  end

  // Status reads return the previous capture, then capture live flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= 8'h00;
      stat_snap <= 2'b00;
    end else if (rd_en) begin
      rdata <= rd_mux;
      if (addr == ADR_STAT) stat_snap <= {period_flag, alarm_flag};
    end
  end

  assign irq_alarm  = alarm_flag;
  assign irq_period = period_flag;

  // R12
  stat_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_STAT) |=> (stat_snap == $past({period_flag, alarm_flag})));

endmodule

// File: tb/rtc_bcd_top_tb_top.sv
`timescale 1ns/1ps
module rtc_bcd_top_tb_top;

  localparam int TPS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32 = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_alarm;
  logic       irq_period;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  rtc_bcd_top #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick32(tick32), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_alarm(irq_alarm), .irq_period(irq_period)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick32 = 1'b1;
      @(negedge clk); tick32 = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s, input logic [2:0] wd);
    wr(4'h5, y); wr(4'h4, mo); wr(4'h3, d); wr(4'h2, h); wr(4'h1, mi);
    wr(4'h6, {5'd0, wd}); wr(4'h0, s);
  endtask

  task automatic chk_time(input string req, input logic [7:0] y, mo, d, h, mi, s);
    logic [7:0] v;
    rd(4'h5, v); chk(req, "year", v, y);
    rd(4'h4, v); chk(req, "month", v, mo);
    rd(4'h3, v); chk(req, "day", v, d);
    rd(4'h2, v); chk(req, "hour", v, h);
    rd(4'h1, v); chk(req, "minute", v, mi);
    rd(4'h0, v); chk(req, "second", v, s);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk_time("R1", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(4'h6, v); chk("R1", "weekday", v, 8'h00);
    rd(4'hD, v); chk("R1", "control", v, 8'h00);
    rd(4'hE, v); chk("R1", "drift", v, 8'h00);
    rd(4'hF, v); chk("R1", "status", v, 8'h00);
    rd(4'hA, v); chk("R1", "alarm day", v, 8'h01);
    chk("R1", "irq_alarm", {7'd0, irq_alarm}, 8'h00);
    chk("R1", "irq_period", {7'd0, irq_period}, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(4'h0, 8'hFF); rd(4'h0, v); chk("R2", "seconds mask", v, 8'h7F);
    wr(4'h2, 8'hFF); rd(4'h2, v); chk("R2", "hours mask", v, 8'h3F);
    wr(4'h3, 8'hFF); rd(4'h3, v); chk("R2", "day mask", v, 8'h3F);
    wr(4'h4, 8'hFF); rd(4'h4, v); chk("R2", "month mask", v, 8'h1F);
    wr(4'h6, 8'hFF); rd(4'h6, v); chk("R2", "weekday mask", v, 8'h07);
    wr(4'hC, 8'h47); rd(4'hC, v); chk("R2", "alarm year", v, 8'h47);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    set_time(8'h10, 8'h06, 8'h15, 8'h12, 8'h34, 8'h00, 3'd1);
    ticks(TPS - 1); rd(4'h0, v); chk("R3", "before step", v, 8'h00);
    ticks(1);       rd(4'h0, v); chk("R3", "after step", v, 8'h01);
    ticks(5); wr(4'h0, 8'h20);
    ticks(TPS - 1); rd(4'h0, v); chk("R3", "restart holds", v, 8'h20);
    ticks(1);       rd(4'h0, v); chk("R3", "restart step", v, 8'h21);
  endtask

  task automatic t_bcd();
    logic [7:0] v;
    set_time(8'h10, 8'h06, 8'h15, 8'h12, 8'h34, 8'h09, 3'd1);
    ticks(TPS); rd(4'h0, v); chk("R4", "units carry 09", v, 8'h10);
    set_time(8'h10, 8'h06, 8'h15, 8'h09, 8'h59, 8'h59, 3'd1);
    ticks(TPS); chk_time("R4", 8'h10, 8'h06, 8'h15, 8'h10, 8'h00, 8'h00);
    set_time(8'h10, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59, 3'd2);
    ticks(TPS); chk_time("R4", 8'h10, 8'h06, 8'h16, 8'h00, 8'h00, 8'h00);
    rd(4'h6, v); chk("R6", "weekday advance", v, 8'h03);
  endtask

  task automatic t_months();
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk_time("R5", 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk_time("R5", 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk_time("R5", 8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk_time("R5", 8'h00, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
    set_time(8'h12, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk_time("R5", 8'h12, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
    set_time(8'h30, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk_time("R5", 8'h30, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h30, 8'h07, 8'h30, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk_time("R5", 8'h30, 8'h07, 8'h31, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_year();
    logic [7:0] v;
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 3'd6);
    ticks(TPS); chk_time("R6", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(4'h6, v); chk("R6", "weekday wrap", v, 8'h00);
  endtask

  task automatic t_round();
    logic [7:0] v;
    set_time(8'h20, 8'h05, 8'h10, 8'h10, 8'h20, 8'h29, 3'd0);
    wr(4'hD, 8'h01);
    rd(4'hD, v); chk("R7", "request pending", v, 8'h01);
    ticks(TPS); chk_time("R7", 8'h20, 8'h05, 8'h10, 8'h10, 8'h20, 8'h00);
    rd(4'hD, v); chk("R7", "request cleared", v, 8'h00);
    set_time(8'h20, 8'h05, 8'h10, 8'h10, 8'h20, 8'h45, 3'd0);
    wr(4'hD, 8'h01);
    ticks(TPS); chk_time("R7", 8'h20, 8'h05, 8'h10, 8'h10, 8'h21, 8'h00);
    set_time(8'h20, 8'h05, 8'h10, 8'h10, 8'h59, 8'h30, 3'd0);
    wr(4'hD, 8'h01);
    ticks(TPS); chk_time("R7", 8'h20, 8'h05, 8'h10, 8'h11, 8'h00, 8'h00);
  endtask

  task automatic t_drift();
    logic [7:0] v;
    wr(4'hE, 8'h03);
    set_time(8'h20, 8'h05, 8'h10, 8'h05, 8'h59, 8'h59, 3'd0);
    ticks(TPS - 4); rd(4'h0, v); chk("R8", "shortened hold", v, 8'h59);
    ticks(1);       rd(4'h2, v); chk("R8", "shortened hour", v, 8'h06);
    set_time(8'h20, 8'h05, 8'h10, 8'h05, 8'h30, 8'h59, 3'd0);
    ticks(TPS - 1); rd(4'h0, v); chk("R8", "non-hour hold", v, 8'h59);
    ticks(1);       rd(4'h1, v); chk("R8", "non-hour step", v, 8'h31);
    wr(4'hE, 8'hFE);
    set_time(8'h20, 8'h05, 8'h10, 8'h05, 8'h59, 8'h59, 3'd0);
    ticks(TPS + 1); rd(4'h0, v); chk("R8", "lengthened hold", v, 8'h59);
    ticks(1);       rd(4'h0, v); chk("R8", "lengthened step", v, 8'h00);
    wr(4'hE, 8'h00);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr(4'h7, 8'h05); wr(4'h8, 8'h30); wr(4'h9, 8'h08);
    wr(4'hA, 8'h15); wr(4'hB, 8'h03); wr(4'hC, 8'h24);
    wr(4'hD, 8'h02);
    set_time(8'h24, 8'h03, 8'h15, 8'h08, 8'h30, 8'h03, 3'd0);
    rd(4'hF, v); rd(4'hF, v); chk("R12", "status idle", v, 8'h00);
    ticks(TPS); chk("R9", "no early alarm", {7'd0, irq_alarm}, 8'h00);
    ticks(TPS); chk("R9", "alarm raised", {7'd0, irq_alarm}, 8'h01);
    rd(4'hF, v); chk("R12", "first read stale", v, 8'h00);
    rd(4'hF, v); chk("R12", "second read fresh", v, 8'h01);
    wr(4'hF, 8'h01); chk("R9", "alarm cleared", {7'd0, irq_alarm}, 8'h00);
    wr(4'hD, 8'h00);
    set_time(8'h24, 8'h03, 8'h15, 8'h08, 8'h30, 8'h04, 3'd0);
    ticks(TPS); chk("R10", "disabled irq", {7'd0, irq_alarm}, 8'h00);
    rd(4'hF, v); rd(4'hF, v); chk("R10", "disabled status", v, 8'h00);
  endtask

  task automatic t_period();
    set_time(8'h24, 8'h03, 8'h15, 8'h00, 8'h00, 8'h58, 3'd0);
    wr(4'hD, 8'h14);
    ticks(TPS); chk("R11", "minute not yet", {7'd0, irq_period}, 8'h00);
    ticks(TPS); chk("R11", "minute event", {7'd0, irq_period}, 8'h01);
    wr(4'hF, 8'h02); chk("R11", "cleared", {7'd0, irq_period}, 8'h00);
    wr(4'hD, 8'h10);
    ticks(TPS); chk("R11", "second event", {7'd0, irq_period}, 8'h01);
    wr(4'hF, 8'h02);
    wr(4'hD, 8'h18);
    set_time(8'h24, 8'h03, 8'h15, 8'h00, 8'h10, 8'h59, 3'd0);
    ticks(TPS); chk("R11", "hour not on minute", {7'd0, irq_period}, 8'h00);
    set_time(8'h24, 8'h03, 8'h15, 8'h00, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk("R11", "hour event", {7'd0, irq_period}, 8'h01);
    wr(4'hF, 8'h02);
    wr(4'hD, 8'h1C);
    set_time(8'h24, 8'h03, 8'h15, 8'h05, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk("R11", "day not on hour", {7'd0, irq_period}, 8'h00);
    set_time(8'h24, 8'h03, 8'h15, 8'h23, 8'h59, 8'h59, 3'd0);
    ticks(TPS); chk("R11", "day event", {7'd0, irq_period}, 8'h01);
    wr(4'hF, 8'h02);
    wr(4'hD, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_prescale();
    t_bcd();
    t_months();
    t_year();
    t_round();
    t_drift();
    t_alarm();
    t_period();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule